// File: doc/BRIEF.md
# Address Translation Region Matcher

This block holds a small table of programmable translation regions and applies them to one request at a time. A request carries a direction (outbound or inbound), a 64-bit address, a 5-bit TLP type, a 3-bit attribute field and an 8-bit message code. Every enabled region compares the request against its own programmed window and match rules. The lowest-indexed region that matches wins. Its index, the translated address, the rewritten attribute and message code, and its programmed response code all come out one clock later with a hit flag.

Software programs each region through a simple write port. A field selector picks the control word, the window base, the window length (limit) or the translation target. A region can invert its window so that it matches only outside it. It can require the request attribute or message code to equal its own before it translates. It can also spread the address bits of a configuration access so that a bus/device/function number lands in bits [31:16] of the result. Only the low `LIMIT_W` bits of a programmed limit are kept, so the block fits parts with either a 40-bit or a 48-bit limit.

Top module: `atu_region_matcher`

## Requirements
- R1: After reset every region is disabled, and `rsp_valid` is low until a lookup is made. A lookup made before any programming misses.
- R2: A region hits only when all of these hold: it is enabled; its direction equals `req_dir` (0 outbound, 1 inbound); its type equals `req_type` (0 memory, 2 I/O, 4 config type 0, 0x10..0x17 message, 0x1F reserved); and `base <= req_addr <= base + limit`. The upper bound is inclusive.
- R3: On a hit without config-shift, `rsp_addr = target + (req_addr - base)`, taken modulo 2^ADDR_W.
- R4: A written limit keeps only its low `LIMIT_W` bits (40 by default). The higher bits have no effect on the window.
- R5: With the invert flag set, the address condition of R2 becomes true only when the address lies outside `base..base+limit`.
- R6: When several regions hit, the one with the lowest index is reported in `rsp_idx`.
- R7: On a miss, `rsp_hit` is 0, `rsp_resp` is 0, and `rsp_addr`, `rsp_attr` and `rsp_msg` equal the request's address, attribute and message code.
- R8: On a hit, `rsp_attr` is the region's attribute and `rsp_resp` is the region's response code (0 normal, 1 unsupported request, 2 completion abort).
- R9: On a hit of an outbound region whose type is a message (type bits [4:3] = 2'b10), `rsp_msg` is the region's message code. For any other hit, `rsp_msg` is the request's code.
- R10: With attribute-match enabled, a region hits only if `req_attr` equals its attribute.
- R11: With message-match enabled, a message-type request hits only if `req_msg` equals the region's message code.
- R12: With config-shift set, the offset `off = req_addr - base` is rearranged before it is added to the target. Offset bits [27:12] go to bits [31:16] and offset bits [11:0] stay in place, so `rsp_addr = target + {off[27:12], 4'b0, off[11:0]}`.
- R13: Write port encoding. `wr_sel` 0 selects the control word, 1 the base, 2 the limit and 3 the target; a write to `wr_idx >= NREG` is ignored. Control word bits, from LSB upward: [0] enable, [1] direction, [6:2] type, [7] invert, [10:8] attribute, [18:11] message code, [19] attribute-match, [20] message-match, [21] config-shift, [23:22] response. A lookup uses the table contents from before any write in the same cycle. Results appear with `rsp_valid` exactly one cycle after `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Region field write strobe |
| wr_idx | input | IDX_W | Region index to write |
| wr_sel | input | 2 | Field selector (ctrl, base, limit, target) |
| wr_data | input | ADDR_W | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_dir | input | 1 | Request direction, 0 outbound, 1 inbound |
| req_addr | input | ADDR_W | Untranslated address |
| req_type | input | 5 | TLP type |
| req_attr | input | 3 | TLP attribute field |
| req_msg | input | 8 | TLP message code |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_hit | output | 1 | A region matched |
| rsp_idx | output | IDX_W | Index of the winning region |
| rsp_addr | output | ADDR_W | Translated (or passed-through) address |
| rsp_attr | output | 3 | Resulting attribute field |
| rsp_msg | output | 8 | Resulting message code |
| rsp_resp | output | 2 | Response code of the winning region |

## Verification
Some properties hold on every cycle and are checked by assertions: the one-cycle result timing, and the pass-through of address, attribute and message code whenever a lookup misses. The arithmetic cannot be checked that way, because it depends on what software programmed. This covers the inclusive window edges, limit truncation, inverted windows, lowest-index priority, attribute and message rewriting, the two match enables and the config-shift placement. Only the directed scenarios show these, against values computed by hand from the programmed regions.

// File: rtl/atu_pkg.sv
package atu_pkg;

   // field selector codes of the write port
   localparam logic [1:0] SEL_CTRL   = 2'd0;
   localparam logic [1:0] SEL_BASE   = 2'd1;
   localparam logic [1:0] SEL_LIMIT  = 2'd2;
   localparam logic [1:0] SEL_TARGET = 2'd3;

   // packed control word, MSB first (24 bits)
   typedef struct packed {
      logic [1:0] resp;
      logic       cfg_shift;
      logic       msg_match;
      logic       attr_match;
      logic [7:0] msg;
      logic [2:0] attr;
      logic       invert;
      logic [4:0] typ;
      logic       dir;
      logic       en;
   } rgn_ctrl_t;

   localparam int CTRL_W = $bits(rgn_ctrl_t);

   function automatic logic is_msg_type(input logic [4:0] t);
      return t[4:3] == 2'b10;
   endfunction

endpackage

// File: rtl/atu_region_regs.sv
module atu_region_regs
   import atu_pkg::*;
#(
   parameter int NREG    = 4,
   parameter int ADDR_W  = 64,
   parameter int LIMIT_W = 40,
   parameter int IDX_W   = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [1:0]                        wr_sel,
   input  logic [ADDR_W-1:0]                 wr_data,
   output rgn_ctrl_t [NREG-1:0]              ctrl_q,
   output logic [NREG-1:0][ADDR_W-1:0]       base_q,
   output logic [NREG-1:0][LIMIT_W-1:0]      limit_q,
   output logic [NREG-1:0][ADDR_W-1:0]       target_q
);

   for (genvar g = 0; g < NREG; g++) begin : g_rgn
      logic sel_me;
      assign sel_me = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[g]   <= '0;
            base_q[g]   <= '0;
            limit_q[g]  <= '0;
            target_q[g] <= '0;
         end else if (sel_me) begin
            case (wr_sel)
               SEL_CTRL:   ctrl_q[g]   <= rgn_ctrl_t'(wr_data[CTRL_W-1:0]);
               SEL_BASE:   base_q[g]   <= wr_data;
               SEL_LIMIT:  limit_q[g]  <= wr_data[LIMIT_W-1:0];
               default:    target_q[g] <= wr_data;
            endcase
         end
      end
   end

endmodule

// File: rtl/atu_region_cmp.sv
module atu_region_cmp
   import atu_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int LIMIT_W = 40
) (
   input  logic                en,
   input  logic                dir,
   input  logic [4:0]          typ,
   input  logic                invert,
   input  logic [2:0]          attr,
   input  logic [7:0]          msg,
   input  logic                attr_match,
   input  logic                msg_match,
   input  logic                cfg_shift,
   input  logic [ADDR_W-1:0]   base,
   input  logic [LIMIT_W-1:0]  limit,
   input  logic [ADDR_W-1:0]   target,
   input  logic                req_dir,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [4:0]          req_type,
   input  logic [2:0]          req_attr,
   input  logic [7:0]          req_msg,
   output logic                hit,
   output logic [ADDR_W-1:0]   xaddr
);

   localparam int EW = ADDR_W + 1;

   logic [EW-1:0]     win_end;
   logic              in_win, addr_ok, attr_ok, msg_ok;
   logic [ADDR_W-1:0] off, moved;

   always_comb begin
      win_end = {1'b0, base} + EW'(limit);
      in_win  = (req_addr >= base) && ({1'b0, req_addr} <= win_end);
      addr_ok = in_win ^ invert;
      attr_ok = !attr_match || (req_attr == attr);
      msg_ok  = !msg_match || !is_msg_type(req_type) || (req_msg == msg);
      hit     = en && (dir == req_dir) && (typ == req_type)
                && addr_ok && attr_ok && msg_ok;
      off     = req_addr - base;
      moved   = cfg_shift ? ADDR_W'({off[27:12], 4'b0000, off[11:0]}) : off;
      xaddr   = target + moved;
   end

endmodule

// File: rtl/atu_first_hit.sv
module atu_first_hit #(
   parameter int NREG  = 4,
   parameter int IDX_W = 2
) (
   input  logic [NREG-1:0]  hits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (hits[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/atu_region_matcher.sv
module atu_region_matcher
   import atu_pkg::*;
#(
   parameter int NREG    = 4,
   parameter int ADDR_W  = 64,
   parameter int LIMIT_W = 40,
   localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              req_valid,
   input  logic              req_dir,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [4:0]        req_type,
   input  logic [2:0]        req_attr,
   input  logic [7:0]        req_msg,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [IDX_W-1:0]  rsp_idx,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [2:0]        rsp_attr,
   output logic [7:0]        rsp_msg,
   output logic [1:0]        rsp_resp
);

   // elaboration-time parameter checks
   if (NREG < 1)                          $error("NREG must be at least 1");
   if (ADDR_W < 32)                       $error("ADDR_W must be at least 32");
   if (LIMIT_W < 12 || LIMIT_W > ADDR_W)  $error("LIMIT_W out of range");
   if (ADDR_W < CTRL_W)                   $error("ADDR_W narrower than control word");

   rgn_ctrl_t [NREG-1:0]          ctrl_q;
   logic [NREG-1:0][ADDR_W-1:0]   base_q, target_q, xaddr;
   logic [NREG-1:0][LIMIT_W-1:0]  limit_q;
   logic [NREG-1:0]               hits;
   logic                          any;
   logic [IDX_W-1:0]              win;

   atu_region_regs #(.NREG(NREG), .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
      .wr_data(wr_data), .ctrl_q(ctrl_q), .base_q(base_q), .limit_q(limit_q),
      .target_q(target_q)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_cmp
      atu_region_cmp #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_cmp (
         .en(ctrl_q[g].en), .dir(ctrl_q[g].dir), .typ(ctrl_q[g].typ),
         .invert(ctrl_q[g].invert), .attr(ctrl_q[g].attr), .msg(ctrl_q[g].msg),
         .attr_match(ctrl_q[g].attr_match), .msg_match(ctrl_q[g].msg_match),
         .cfg_shift(ctrl_q[g].cfg_shift), .base(base_q[g]), .limit(limit_q[g]),
         .target(target_q[g]), .req_dir(req_dir), .req_addr(req_addr),
         .req_type(req_type), .req_attr(req_attr), .req_msg(req_msg),
         .hit(hits[g]), .xaddr(xaddr[g])
      );
   end

   atu_first_hit #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
      .hits(hits), .any(any), .idx(win)
   );

   rgn_ctrl_t         wc;
   logic [ADDR_W-1:0] nx_addr;
   logic [2:0]        nx_attr;
   logic [7:0]        nx_msg;
   logic [1:0]        nx_resp;

   always_comb begin
      wc      = ctrl_q[win];
      nx_addr = req_addr;
      nx_attr = req_attr;
      nx_msg  = req_msg;
      nx_resp = 2'd0;
      if (any) begin
         nx_addr = xaddr[win];
         nx_attr = wc.attr;
         nx_resp = wc.resp;
         if (!wc.dir && is_msg_type(wc.typ)) nx_msg = wc.msg;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_idx   <= '0;
         rsp_addr  <= '0;
         rsp_attr  <= '0;
         rsp_msg   <= '0;
         rsp_resp  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && any;
         rsp_idx   <= win;
         rsp_addr  <= nx_addr;
         rsp_attr  <= nx_attr;
         rsp_msg   <= nx_msg;
         rsp_resp  <= nx_resp;
      end
   end

   // R13
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R13
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R7
   miss_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> rsp_addr == $past(req_addr));
   // R7
   miss_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> rsp_attr == $past(req_attr));
   // R7
   miss_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> rsp_msg == $past(req_msg));

endmodule

// File: tb/sim_atu_region_matcher.sv
module sim_atu_region_matcher;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic [1:0]  wr_sel = '0;
   logic [63:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic        req_dir = 1'b0;
   logic [63:0] req_addr = '0;
   logic [4:0]  req_type = '0;
   logic [2:0]  req_attr = '0;
   logic [7:0]  req_msg = '0;
   logic        rsp_valid, rsp_hit;
   logic [1:0]  rsp_idx;
   logic [63:0] rsp_addr;
   logic [2:0]  rsp_attr;
   logic [7:0]  rsp_msg;
   logic [1:0]  rsp_resp;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   atu_region_matcher u0 (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] mkctrl(input logic en, input logic dir, input logic [4:0] typ,
      input logic inv, input logic [2:0] attr, input logic [7:0] msg, input logic ame,
      input logic mme, input logic csh, input logic [1:0] resp);
      return 64'({resp, csh, mme, ame, msg, attr, inv, typ, dir, en});
   endfunction

   task automatic wr(input logic [1:0] idx, input logic [1:0] sel, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic region(input logic [1:0] idx, input logic [63:0] c, input logic [63:0] b,
                         input logic [63:0] l, input logic [63:0] t);
      wr(idx, 2'd1, b); wr(idx, 2'd2, l); wr(idx, 2'd3, t); wr(idx, 2'd0, c);
   endtask

   task automatic look(input logic dir, input logic [63:0] a, input logic [4:0] typ,
                       input logic [2:0] at, input logic [7:0] m);
      @(negedge clk);
      req_valid = 1'b1; req_dir = dir; req_addr = a; req_type = typ; req_attr = at; req_msg = m;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      look(1'b0, 64'h1234, 5'd0, 3'd1, 8'h00);
      chk("R1 valid one cycle later", 64'(rsp_valid), 64'd1);
      chk("R1 no region hits", 64'(rsp_hit), 64'd0);
      chk("R7 passthrough addr", rsp_addr, 64'h1234);
      chk("R7 resp zero on miss", 64'(rsp_resp), 64'd0);
   endtask

   task automatic t_basic();
      region(2'd0, mkctrl(1,0,5'd0,0,3'd3,8'h00,0,0,0,2'd0), 64'h1_0000_0000, 64'hFFFF, 64'h8000_0000);
      look(1'b0, 64'h1_0000_1000, 5'd0, 3'd0, 8'h00);
      chk("R2 hit inside", 64'(rsp_hit), 64'd1);
      chk("R3 translated", rsp_addr, 64'h8000_1000);
      chk("R8 attr override", 64'(rsp_attr), 64'd3);
      look(1'b0, 64'h1_0000_FFFF, 5'd0, 3'd0, 8'h00);
      chk("R2 inclusive upper edge", 64'(rsp_hit), 64'd1);
      chk("R3 edge address", rsp_addr, 64'h8000_FFFF);
      look(1'b0, 64'h1_0001_0000, 5'd0, 3'd0, 8'h00);
      chk("R2 past upper edge", 64'(rsp_hit), 64'd0);
      look(1'b0, 64'h0_FFFF_FFFF, 5'd0, 3'd0, 8'h00);
      chk("R2 below base", 64'(rsp_hit), 64'd0);
      look(1'b0, 64'h1_0000_1000, 5'd2, 3'd0, 8'h00);
      chk("R2 type mismatch", 64'(rsp_hit), 64'd0);
      look(1'b1, 64'h1_0000_1000, 5'd0, 3'd0, 8'h00);
      chk("R2 direction mismatch", 64'(rsp_hit), 64'd0);
   endtask

   task automatic t_priority();
      region(2'd1, mkctrl(1,0,5'd0,0,3'd1,8'h00,0,0,0,2'd2), 64'h1_0000_0000, 64'hF_FFFF, 64'h2000_0000);
      look(1'b0, 64'h1_0000_1000, 5'd0, 3'd0, 8'h00);
      chk("R6 lowest index wins", 64'(rsp_idx), 64'd0);
      chk("R6 winner address", rsp_addr, 64'h8000_1000);
      wr(2'd0, 2'd0, mkctrl(0,0,5'd0,0,3'd3,8'h00,0,0,0,2'd0));
      look(1'b0, 64'h1_0000_1000, 5'd0, 3'd0, 8'h00);
      chk("R6 next region after disable", 64'(rsp_idx), 64'd1);
      chk("R3 second region address", rsp_addr, 64'h2000_1000);
      chk("R8 completion abort code", 64'(rsp_resp), 64'd2);
   endtask

   task automatic t_invert();
      region(2'd2, mkctrl(1,1,5'd0,1,3'd6,8'h00,0,0,0,2'd1), 64'h4000, 64'hFFF, 64'h9000_0000);
      look(1'b1, 64'h4800, 5'd0, 3'd0, 8'h00);
      chk("R5 inside inverted window misses", 64'(rsp_hit), 64'd0);
      look(1'b1, 64'h6000, 5'd0, 3'd0, 8'h00);
      chk("R5 outside inverted window hits", 64'(rsp_hit), 64'd1);
      chk("R5 inverted translation", rsp_addr, 64'h9000_2000);
      chk("R8 unsupported request code", 64'(rsp_resp), 64'd1);
   endtask

   task automatic t_limit();
      region(2'd3, mkctrl(1,0,5'd0,0,3'd0,8'h00,0,0,0,2'd0), 64'h100, 64'hFF00_0000_0000_00FF, 64'h7000);
      look(1'b0, 64'h1FF, 5'd0, 3'd0, 8'h00);
      chk("R4 truncated limit edge hit", rsp_addr, 64'h70FF);
      look(1'b0, 64'h200, 5'd0, 3'd0, 8'h00);
      chk("R4 upper limit bits ignored", 64'(rsp_hit), 64'd0);
   endtask

   task automatic t_attr_match();
      wr(2'd3, 2'd0, mkctrl(1,0,5'd0,0,3'd5,8'h00,1,0,0,2'd0));
      look(1'b0, 64'h150, 5'd0, 3'd5, 8'h00);
      chk("R10 equal attribute hits", rsp_addr, 64'h7050);
      look(1'b0, 64'h150, 5'd0, 3'd2, 8'h00);
      chk("R10 unequal attribute misses", 64'(rsp_hit), 64'd0);
      chk("R7 attribute passthrough", 64'(rsp_attr), 64'd2);
   endtask

   task automatic t_msg();
      wr(2'd3, 2'd0, mkctrl(1,0,5'h10,0,3'd0,8'h7E,0,0,0,2'd0));
      look(1'b0, 64'h150, 5'h10, 3'd0, 8'h11);
      chk("R9 outbound message rewritten", 64'(rsp_msg), 64'h7E);
      wr(2'd3, 2'd0, mkctrl(1,0,5'h10,0,3'd0,8'h20,0,1,0,2'd0));
      look(1'b0, 64'h150, 5'h10, 3'd0, 8'h11);
      chk("R11 code mismatch misses", 64'(rsp_hit), 64'd0);
      chk("R7 message passthrough", 64'(rsp_msg), 64'h11);
      look(1'b0, 64'h150, 5'h10, 3'd0, 8'h20);
      chk("R11 code match hits", 64'(rsp_hit), 64'd1);
      wr(2'd2, 2'd0, mkctrl(1,1,5'h10,0,3'd0,8'h55,0,0,0,2'd0));
      look(1'b1, 64'h4010, 5'h10, 3'd0, 8'h11);
      chk("R9 inbound hit", 64'(rsp_hit), 64'd1);
      chk("R9 inbound message kept", 64'(rsp_msg), 64'h11);
   endtask

   task automatic t_cfg_shift();
      region(2'd3, mkctrl(1,0,5'd4,0,3'd0,8'h00,0,0,1,2'd0), 64'h1000_0000, 64'h0FFF_FFFF, 64'h4_0000_0000);
      look(1'b0, 64'h1ABC_D123, 5'd4, 3'd0, 8'h00);
      chk("R12 config shift hit", 64'(rsp_idx), 64'd3);
      chk("R12 config shift address", rsp_addr, 64'h4_ABCD_0123);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_priority();
      t_invert();
      t_limit();
      t_attr_match();
      t_msg();
      t_cfg_shift();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule